// File: doc/BRIEF.md
# Variable Speed Stepper Phase Sequencer

The block turns one 8-bit unsigned speed word into the drive pattern for a four-coil stepper motor. Mid-scale (128) means stopped. Codes above it run the motor forward, faster as the code rises. Codes below it run the motor in reverse, faster as the code falls. A free-running counter is matched by equality against a compare register, and each match is one step event. At a step event the compare register moves ahead by a half-period delay. The phase state machine then moves one entry forward, one entry back, or stays where it is, in a four-entry table of one-hot coil patterns. The table wraps at both ends.

The speed word is captured only at step events. A captured value governs the step after that event: its direction moves the phase, and its delay spaces the next compare. Changes to the input between events leave the step already scheduled untouched. The phase machine has four states, `PH_0`, `PH_1`, `PH_2` and `PH_3`, and three transitions:
- `ADVANCE`: PH_0→PH_1→PH_2→PH_3→PH_0.
- `RETREAT`: PH_0→PH_3→PH_2→PH_1→PH_0.
- `HOLD`: the state does not change.

The captured direction (`DIR_FWD`, `DIR_REV` or `DIR_HOLD`) picks the transition at each step event.

Top module: `stp_speed_ctrl`

## Requirements
- R1: During reset and after it, `coil_o` is 4'b0001. The compare register starts at 2^(CNT_W-1), the delay register starts at 2^(CNT_W-1) and the captured direction starts at hold, so the first step event, at count 2^(CNT_W-1), does not change the coils.
- R2: The signed speed is `speed_in` − 128. It gives direction forward when positive, reverse when negative and hold when zero (`speed_in` = 128).
- R3: `coil_o` bit i drives coil i. The states show 4'b0001 (PH_0), 4'b0100 (PH_1), 4'b0010 (PH_2) and 4'b1000 (PH_3), so the coils energise in the order 0, 2, 1, 3. Exactly one bit is high.
- R4: A forward step from PH_3 goes to PH_0. A reverse step from PH_0 goes to PH_3. Otherwise forward adds one to the phase index and reverse subtracts one.
- R5: At a step event the new compare value is the old compare value plus the captured delay, modulo 2^CNT_W. The current count is not used.
- R6: The delay is CNT_W bits. Its top 8 bits are 255 − 2·min(|signed speed|, 127) and its lower CNT_W−8 bits are zero, so a larger speed gives a shorter delay.
- R7: `speed_in` is sampled only at a step event. Its direction and delay take effect at the following step event. Input changes between events change neither the coils nor the pending compare value.
- R8: With direction hold, step events still occur but `coil_o` stays constant.
- R9: The counter is CNT_W bits wide. It advances by one every clock and wraps from 2^CNT_W−1 to 0, and matches across the wrap behave the same as other matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_in | input | SPD_W (8) | Unsigned speed word, offset by 128 |
| coil_o | output | 4 | One-hot coil drive, bit i to coil i |

## Verification
A step event and a change of the speed word can fall in the same cycle. The new word must then be captured by that event, yet steer only the following step, while the phase move and compare advance of this event still use the previous word. The bench provokes this by watching its own model and writing a new speed word in the cycle just before the count reaches the compare value. It does this many times, with reversals of direction. A behavioural model built from the requirements judges the result: it predicts the coil pattern, and the bench compares it with the design every clock.

// File: rtl/stp_pkg.sv
package stp_pkg;

    // Direction captured from the biased speed word.
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_FWD  = 2'd1,
        DIR_REV  = 2'd2
    } stp_dir_e;

    // Phase states; the index is the coil table entry.
    typedef enum logic [1:0] {
        PH_0 = 2'd0,
        PH_1 = 2'd1,
        PH_2 = 2'd2,
        PH_3 = 2'd3
    } stp_phase_e;

    localparam int unsigned COIL_N = 4;

endpackage

// File: rtl/stp_speed_decode.sv
module stp_speed_decode
    import stp_pkg::*;
#(
    parameter int unsigned SPD_W = 8
) (
    input  logic [SPD_W-1:0] speed_i,
    output stp_dir_e         dir_o,
    output logic [SPD_W-1:0] dly_hi_o
);
    localparam logic [SPD_W-1:0] MID  = {1'b1, {(SPD_W-1){1'b0}}};
    localparam logic [SPD_W-1:0] MAXM = MID - 1'b1;

    logic [SPD_W-1:0] mag;
    logic [SPD_W-1:0] mag_sat;
    logic [SPD_W-1:0] mag_dbl;

    always_comb begin
        if (speed_i > MID) begin
            dir_o = DIR_FWD;
            mag   = speed_i - MID;
        end else if (speed_i < MID) begin
            dir_o = DIR_REV;
            mag   = MID - speed_i;
        end else begin
            dir_o = DIR_HOLD;
            mag   = '0;
        end
        mag_sat  = (mag > MAXM) ? MAXM : mag;
        mag_dbl  = mag_sat << 1;
        dly_hi_o = ~mag_dbl;
    end

    always_comb begin
        AST_HOLD_ONLY_AT_MID: assert ((dir_o == DIR_HOLD) == (speed_i == MID)); // R2
    end

endmodule

// File: rtl/stp_step_timer.sv
module stp_step_timer #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned HI_W  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [HI_W-1:0] dly_hi_i,
    output logic            step_o
);
    localparam int unsigned LO_W = CNT_W - HI_W;
    localparam logic [CNT_W-1:0] RST_DLY = {1'b1, {(CNT_W-1){1'b0}}};

    logic [CNT_W-1:0] tmr_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] dly_q;

    assign step_o = (tmr_q == cmp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
            cmp_q <= RST_DLY;
            dly_q <= RST_DLY;
        end else begin
            tmr_q <= tmr_q + 1'b1;
            if (step_o) begin
                cmp_q <= cmp_q + dly_q;
                dly_q <= {dly_hi_i, {LO_W{1'b0}}};
            end
        end
    end

    AST_TMR_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> tmr_q == $past(tmr_q) + 1'b1); // R9

    AST_CMP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> cmp_q == $past(cmp_q) + $past(dly_q)); // R5

    AST_CMP_UNDISTURBED: assert property (@(posedge clk) disable iff (!rst_n)
        !step_o |=> $stable(cmp_q) && $stable(dly_q)); // R7

    AST_DLY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        dly_q != '0); // R6

endmodule

// File: rtl/stp_phase_fsm.sv
module stp_phase_fsm
    import stp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  stp_dir_e          dir_i,
    output logic [COIL_N-1:0] coil_o
);
    stp_phase_e state_q, state_d;
    stp_dir_e   dir_q;

    // Next-state selection: ADVANCE, RETREAT or HOLD.
    always_comb begin
        state_d = state_q;
        if (step_i) begin
            unique case (state_q)
                PH_0: state_d = (dir_q == DIR_FWD) ? PH_1 :
                                (dir_q == DIR_REV) ? PH_3 : PH_0;
                PH_1: state_d = (dir_q == DIR_FWD) ? PH_2 :
                                (dir_q == DIR_REV) ? PH_0 : PH_1;
                PH_2: state_d = (dir_q == DIR_FWD) ? PH_3 :
                                (dir_q == DIR_REV) ? PH_1 : PH_2;
                PH_3: state_d = (dir_q == DIR_FWD) ? PH_0 :
                                (dir_q == DIR_REV) ? PH_2 : PH_3;
            endcase
        end
    end

    // State register and captured direction.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_0;
            dir_q   <= DIR_HOLD;
        end else begin
            state_q <= state_d;
            if (step_i) begin
                dir_q <= dir_i;
            end
        end
    end

    // Coil table: coils energised in the order 0, 2, 1, 3.
    always_comb begin
        unique case (state_q)
            PH_0: coil_o = 4'b0001;
            PH_1: coil_o = 4'b0100;
            PH_2: coil_o = 4'b0010;
            PH_3: coil_o = 4'b1000;
        endcase
    end

    AST_COIL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(coil_o) == 1); // R3

    AST_NO_STEP_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(state_q) && $stable(dir_q)); // R7

    AST_HOLD_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && dir_q == DIR_HOLD) |=> $stable(coil_o)); // R8

    AST_FWD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && dir_q == DIR_FWD && coil_o == 4'b1000) |=> coil_o == 4'b0001); // R4

    AST_REV_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && dir_q == DIR_REV && coil_o == 4'b0001) |=> coil_o == 4'b1000); // R4

endmodule

// File: rtl/stp_speed_ctrl.sv
module stp_speed_ctrl
    import stp_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned SPD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SPD_W-1:0] speed_in,
    output logic [3:0]       coil_o
);
    stp_dir_e         dir_new;
    logic [SPD_W-1:0] dly_hi;
    logic             step;

    stp_speed_decode #(.SPD_W(SPD_W)) u_decode (
        .speed_i  (speed_in),
        .dir_o    (dir_new),
        .dly_hi_o (dly_hi)
    );

    stp_step_timer #(.CNT_W(CNT_W), .HI_W(SPD_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .dly_hi_i (dly_hi),
        .step_o   (step)
    );

    stp_phase_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .dir_i  (dir_new),
        .coil_o (coil_o)
    );

    initial begin
        AST_WIDTH_OK: assert (CNT_W > SPD_W && SPD_W >= 2); // R6
    end

endmodule

// File: tb/stp_speed_ctrl_tb.sv
module stp_speed_ctrl_tb_top;
    localparam int CW = 12;
    localparam int M  = 1 << CW;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] speed = 8'd128;
    logic [3:0] coil;

    always #5 clk = ~clk;

    stp_speed_ctrl #(.CNT_W(CW), .SPD_W(8)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .speed_in (speed),
        .coil_o   (coil)
    );

    int    m_tmr, m_cmp, m_dly, m_dir, m_ptr;
    int    edges = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";
    bit    done = 1'b0;

    function automatic int f_dir(int sp);
        if (sp > 128) return 1;
        if (sp < 128) return -1;
        return 0;
    endfunction

    function automatic int f_dly(int sp);
        int mag;
        mag = (sp >= 128) ? sp - 128 : 128 - sp;
        if (mag > 127) mag = 127;
        return (255 - 2 * mag) << (CW - 8);
    endfunction

    function automatic int f_pat(int p);
        case (p)
            0: return 1;
            1: return 4;
            2: return 2;
            default: return 8;
        endcase
    endfunction

    // Behavioural reference model, advanced on every clock.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_tmr = 0; m_cmp = M / 2; m_dly = M / 2; m_dir = 0; m_ptr = 0;
        end else begin
            edges = edges + 1;
            if (m_tmr == m_cmp) begin
                m_ptr = (m_ptr + m_dir + 4) % 4;
                m_cmp = (m_cmp + m_dly) % M;
                m_dir = f_dir(int'(speed));
                m_dly = f_dly(int'(speed));
            end
            m_tmr = (m_tmr + 1) % M;
        end
    end

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_cmp++;
            if (coil !== 4'(f_pat(m_ptr))) begin
                n_bad++;
                $display("FAIL %s coil_o actual=%b expected=%b at edge %0d",
                         tag, coil, 4'(f_pat(m_ptr)), edges);
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_to(int n);
        while (edges < n) @(negedge clk);
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        run(190000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int hold_pat;
        run(3);
        chk("R1 coil in reset", int'(coil), 1);
        rst_n = 1'b1;
        tag = "R1";
        wait_to(100);
        speed = 8'd200;                  // R2 forward, R6 delay 111*16 = 1776
        wait_to(2049);
        chk("R1 first event holds", int'(coil), 1);
        tag = "R9";
        wait_to(4096);
        chk("R9 before wrap event", int'(coil), 1);
        wait_to(4097);
        chk("R3 entry1 after wrap event", int'(coil), 4);
        tag = "R5";
        wait_to(5872);
        chk("R5 one cycle before compare", int'(coil), 4);
        wait_to(5873);
        chk("R5 compare from previous compare", int'(coil), 2);

        tag = "R4";
        speed = 8'd255;                  // R4 fast forward wraps
        run(2500);
        speed = 8'd0;                    // R4 fast reverse wraps
        run(2500);

        tag = "R8";
        speed = 8'd128;                  // R8 stop
        run(300);
        hold_pat = int'(coil);
        run(3000);
        chk("R8 hold keeps coils", int'(coil), hold_pat);

        tag = "R6";
        speed = 8'd129;                  // R6 slowest forward
        run(9000);
        speed = 8'd127;                  // R2 slowest reverse
        run(9000);

        tag = "R7";
        for (int i = 0; i < 500; i++) begin
            speed = 8'($urandom_range(0, 255));
            run(int'($urandom_range(5, 60)));
        end

        tag = "R7 coincident";
        for (int i = 0; i < 60; i++) begin
            while (m_tmr != m_cmp) @(negedge clk);
            if (i % 2 == 0) speed = 8'($urandom_range(0, 30));
            else            speed = 8'($urandom_range(225, 255));
            @(negedge clk);
        end
        run(200);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule